// File: doc/BRIEF.md
# Calendar Clock with BCD Year

A real-time calendar counter that holds the time of day and date as packed binary fields in one 32-bit word and the year as four BCD digits in a separate 16-bit word. Each one-cycle `tick_i` strobe, normally one per second, advances the calendar by one second. Rollover runs from seconds up through the year and follows the Gregorian month lengths and leap-year rule.

Both words can be overwritten through their own load ports. The current words are always visible on the read ports. An alarm compares the advanced time and year against two match words. It raises a single-cycle pulse when a tick lands exactly on the programmed instant. Tick generation and any bus wrapper sit outside the block.

Top module: `bcd_cal_rtc`

## Requirements
- R1: After reset the time word reads 0x021E0000, which is month 1, day 1, weekday 7, 00:00:00. The year word reads 0x2000.
- R2: The time word layout is seconds in bits 5:0, minutes in 11:6, hours in 16:12, weekday in 19:17 (1 = Sunday), day of month in 24:20 and month in 28:25 (1 = January). A tick with no load advances seconds by one. In a cycle with no tick and no load, both words hold.
- R3: Seconds and minutes wrap from 59 to 0, and hours wrap from 23 to 0. Each wrap carries into the next field.
- R4: On the tick after 23:59:59 the day of month increments and the weekday advances, wrapping from 7 to 1.
- R5: The day of month wraps to 1 after day 30 for months 4, 6, 9 and 11, and after day 31 for the other non-February months. Each such wrap carries into the month.
- R6: February ends on day 29 in a leap year and on day 28 otherwise. A leap year is divisible by 4, except that a century year must also be divisible by 400.
- R7: After December 31 the month returns to 1 and the year increments in BCD, carrying from the year-in-century byte (bits 7:0) into the century byte (bits 15:8). Year 9999 wraps to 0000.
- R8: A load pulse writes its word on the next clock edge. Bits 31:29 of the time word keep the value last loaded. Any load in a cycle blocks that cycle's tick for both words.
- R9: `alarm_o` is high for exactly one clock cycle, starting at the edge where a tick advances the time and year words to equal `time_match_i` and `year_match_i`.
- R10: No alarm is raised when only the time word matches, or when a load writes values equal to the match words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | One-second advance strobe |
| time_load_i | input | 1 | Load strobe for the time word |
| time_load_val_i | input | 32 | Time word to load |
| year_load_i | input | 1 | Load strobe for the year word |
| year_load_val_i | input | 16 | BCD year to load |
| time_match_i | input | 32 | Alarm time match word |
| year_match_i | input | 16 | Alarm BCD year match word |
| time_o | output | 32 | Current packed time word |
| year_o | output | 16 | Current BCD year |
| alarm_o | output | 1 | Single-cycle alarm pulse |

## Verification
Reaching the deep carries, such as a century boundary, a leap day in a century year or the 9999 wrap, would take years of ticks from reset. The bench therefore loads both words to one second before each boundary and then issues a single tick. A table of such pre-boundary states covers every month-length class, the three leap-rule branches, the weekday wrap and each decimal carry of the year. Directed cases then check alarm coincidence, an alarm blocked by a year mismatch, and a load that collides with a tick.

// File: rtl/bcd_cal_pkg.sv
package bcd_cal_pkg;
  localparam int TIME_W  = 32;
  localparam int DIG_W   = 4;
  localparam int YEAR_DIGITS = 4;
  localparam int YEAR_W  = DIG_W * YEAR_DIGITS;
  localparam int SEC_MAX  = 59;
  localparam int MIN_MAX  = 59;
  localparam int HOUR_MAX = 23;
  localparam int WDAY_MAX = 7;
  localparam int MON_MAX  = 12;

  // packed fields: sec[5:0] min[11:6] hour[16:12] wday[19:17] mday[24:20] mon[28:25]
  typedef struct packed {
    logic [3:0] mon;
    logic [4:0] mday;
    logic [2:0] wday;
    logic [4:0] hour;
    logic [5:0] min;
    logic [5:0] sec;
  } cal_time_t;

  localparam int FIELD_W = $bits(cal_time_t);
  localparam int SPARE_W = TIME_W - FIELD_W;

  function automatic logic bcd_byte_div4(input logic [7:0] b);
    logic [3:0] u;
    u = b[3:0];
    if (!b[4]) return (u == 4'd0) || (u == 4'd4) || (u == 4'd8);
    else       return (u == 4'd2) || (u == 4'd6);
  endfunction

  function automatic logic bcd_is_leap(input logic [15:0] y);
    if (y[7:0] == 8'h00) return bcd_byte_div4(y[15:8]);
    else                 return bcd_byte_div4(y[7:0]);
  endfunction

  function automatic logic [4:0] month_days(input logic [3:0] mon, input logic leap);
    case (mon)
      4'd2:                      return leap ? 5'd29 : 5'd28;
      4'd4, 4'd6, 4'd9, 4'd11:   return 5'd30;
      default:                   return 5'd31;
    endcase
  endfunction
endpackage

// File: rtl/cal_time_inc.sv
module cal_time_inc
  import bcd_cal_pkg::*;
(
  input  cal_time_t cur_i,
  input  logic      leap_i,
  output cal_time_t nxt_o,
  output logic      year_carry_o
);
  logic c_min, c_hour, c_day, c_mon;
  logic [4:0] dim;

  always_comb begin
    nxt_o = cur_i;
    dim   = month_days(cur_i.mon, leap_i);
    c_min = 1'b0; c_hour = 1'b0; c_day = 1'b0; c_mon = 1'b0;

    if (cur_i.sec >= 6'(SEC_MAX)) begin
      nxt_o.sec = '0; c_min = 1'b1;
    end else nxt_o.sec = cur_i.sec + 6'd1;

    if (c_min) begin
      if (cur_i.min >= 6'(MIN_MAX)) begin
        nxt_o.min = '0; c_hour = 1'b1;
      end else nxt_o.min = cur_i.min + 6'd1;
    end

    if (c_hour) begin
      if (cur_i.hour >= 5'(HOUR_MAX)) begin
        nxt_o.hour = '0; c_day = 1'b1;
      end else nxt_o.hour = cur_i.hour + 5'd1;
    end

    if (c_day) begin
      nxt_o.wday = (cur_i.wday >= 3'(WDAY_MAX)) ? 3'd1 : cur_i.wday + 3'd1;
      if (cur_i.mday >= dim) begin
        nxt_o.mday = 5'd1; c_mon = 1'b1;
      end else nxt_o.mday = cur_i.mday + 5'd1;
    end

    if (c_mon) begin
      if (cur_i.mon >= 4'(MON_MAX)) begin
        nxt_o.mon = 4'd1; year_carry_o = 1'b1;
      end else begin
        nxt_o.mon = cur_i.mon + 4'd1; year_carry_o = 1'b0;
      end
    end else year_carry_o = 1'b0;
  end

  // R4 weekday wrap at day end
  always_comb begin
    if (cur_i.sec == 6'd59 && cur_i.min == 6'd59 && cur_i.hour == 5'd23 && cur_i.wday == 3'd7)
      p_wday_wrap_r4: assert (nxt_o.wday == 3'd1);
  end
endmodule

// File: rtl/bcd_year_inc.sv
module bcd_year_inc #(
  parameter int DIGITS = 4,
  parameter int DW     = 4,
  localparam int W     = DIGITS * DW
) (
  input  logic [W-1:0] year_i,
  input  logic         inc_i,
  output logic [W-1:0] year_o
);
  logic [DIGITS:0] carry;
  assign carry[0] = inc_i;

  for (genvar g = 0; g < DIGITS; g++) begin : g_digit
    logic [DW-1:0] d;
    assign d = year_i[g*DW +: DW];
    always_comb begin
      if (!carry[g]) begin
        year_o[g*DW +: DW] = d;
        carry[g+1] = 1'b0;
      end else if (d >= DW'(9)) begin
        year_o[g*DW +: DW] = '0;
        carry[g+1] = 1'b1;
      end else begin
        year_o[g*DW +: DW] = d + DW'(1);
        carry[g+1] = 1'b0;
      end
    end
  end

  // R7 top-of-range wrap
  always_comb begin
    if (inc_i && year_i == {DIGITS{DW'(9)}})
      p_year_wrap_r7: assert (year_o == '0);
  end
endmodule

// File: rtl/cal_alarm.sv
module cal_alarm #(
  parameter int TW = 32,
  parameter int YW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          adv_i,
  input  logic [TW-1:0] time_nxt_i,
  input  logic [YW-1:0] year_nxt_i,
  input  logic [TW-1:0] time_match_i,
  input  logic [YW-1:0] year_match_i,
  output logic          alarm_o
);
  logic hit;
  assign hit = adv_i && (time_nxt_i == time_match_i) && (year_nxt_i == year_match_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) alarm_o <= 1'b0;
    else         alarm_o <= hit;
  end

  // R9 alarm never lasts two cycles: the seconds field moves on every advance
  p_alarm_pulse_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    alarm_o |=> !alarm_o);
endmodule

// File: rtl/bcd_cal_rtc.sv
module bcd_cal_rtc
  import bcd_cal_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              time_load_i,
  input  logic [TIME_W-1:0] time_load_val_i,
  input  logic              year_load_i,
  input  logic [YEAR_W-1:0] year_load_val_i,
  input  logic [TIME_W-1:0] time_match_i,
  input  logic [YEAR_W-1:0] year_match_i,
  output logic [TIME_W-1:0] time_o,
  output logic [YEAR_W-1:0] year_o,
  output logic              alarm_o
);
  localparam cal_time_t   RST_TIME = '{mon: 4'd1, mday: 5'd1, wday: 3'd7,
                                       hour: '0, min: '0, sec: '0};
  localparam logic [YEAR_W-1:0] RST_YEAR = YEAR_W'(16'h2000);

  cal_time_t           time_q, time_nxt;
  logic [SPARE_W-1:0]  spare_q;
  logic [YEAR_W-1:0]   year_q, year_nxt;
  logic                adv, year_carry, leap;

  assign adv  = tick_i && !time_load_i && !year_load_i;
  assign leap = bcd_is_leap(year_q);

  cal_time_inc u_time_inc (
    .cur_i        (time_q),
    .leap_i       (leap),
    .nxt_o        (time_nxt),
    .year_carry_o (year_carry)
  );

  bcd_year_inc #(.DIGITS(YEAR_DIGITS), .DW(DIG_W)) u_year_inc (
    .year_i (year_q),
    .inc_i  (year_carry),
    .year_o (year_nxt)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      time_q  <= RST_TIME;
      spare_q <= '0;
      year_q  <= RST_YEAR;
    end else begin
      if (time_load_i) begin
        time_q  <= cal_time_t'(time_load_val_i[FIELD_W-1:0]);
        spare_q <= time_load_val_i[TIME_W-1:FIELD_W];
      end else if (adv) begin
        time_q  <= time_nxt;
      end
      if (year_load_i)  year_q <= year_load_val_i;
      else if (adv)     year_q <= year_nxt;
    end
  end

  cal_alarm #(.TW(TIME_W), .YW(YEAR_W)) u_alarm (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .adv_i        (adv),
    .time_nxt_i   ({spare_q, time_nxt}),
    .year_nxt_i   (year_nxt),
    .time_match_i (time_match_i),
    .year_match_i (year_match_i),
    .alarm_o      (alarm_o)
  );

  assign time_o = {spare_q, time_q};
  assign year_o = year_q;

  p_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tick_i && !time_load_i && !year_load_i) |=> ($stable(time_o) && $stable(year_o)));

  p_sec_step_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adv && time_o[5:0] < 6'd59) |=> (time_o[5:0] == $past(time_o[5:0]) + 6'd1));

  p_load_time_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    time_load_i |=> (time_o == $past(time_load_val_i)));

  p_load_year_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    year_load_i |=> (year_o == $past(year_load_val_i)));

  p_no_alarm_on_load_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (time_load_i || year_load_i) |=> !alarm_o);
endmodule

// File: tb/bcd_cal_rtc_tb_top.sv
module bcd_cal_rtc_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 15;

  function automatic logic [31:0] pk(input int mo, input int d, input int w,
                                     input int h, input int mi, input int s);
    return {3'b000, 4'(mo), 5'(d), 3'(w), 5'(h), 6'(mi), 6'(s)};
  endfunction

  // {time_in, year_in, time_expected, year_expected}
  localparam logic [95:0] VEC [NVEC] = '{
    {pk(1,1,7,0,0,0),     16'h2000, pk(1,1,7,0,0,1),    16'h2000},
    {pk(3,9,2,12,34,59),  16'h2011, pk(3,9,2,12,35,0),  16'h2011},
    {pk(6,2,5,5,59,59),   16'h1987, pk(6,2,5,6,0,0),    16'h1987},
    {pk(1,15,7,23,59,59), 16'h2023, pk(1,16,1,0,0,0),   16'h2023},
    {pk(2,28,4,23,59,59), 16'h2024, pk(2,29,5,0,0,0),   16'h2024},
    {pk(2,28,3,23,59,59), 16'h2023, pk(3,1,4,0,0,0),    16'h2023},
    {pk(2,29,5,23,59,59), 16'h2024, pk(3,1,6,0,0,0),    16'h2024},
    {pk(2,28,4,23,59,59), 16'h1900, pk(3,1,5,0,0,0),    16'h1900},
    {pk(2,28,2,23,59,59), 16'h2000, pk(2,29,3,0,0,0),   16'h2000},
    {pk(4,30,3,23,59,59), 16'h2015, pk(5,1,4,0,0,0),    16'h2015},
    {pk(1,31,6,23,59,59), 16'h2015, pk(2,1,7,0,0,0),    16'h2015},
    {pk(12,31,3,23,59,59),16'h2019, pk(1,1,4,0,0,0),    16'h2020},
    {pk(12,31,5,23,59,59),16'h2099, pk(1,1,6,0,0,0),    16'h2100},
    {pk(12,31,6,23,59,59),16'h9999, pk(1,1,7,0,0,0),    16'h0000},
    {pk(12,31,6,23,59,59),16'h1999, pk(1,1,7,0,0,0),    16'h2000}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick = 1'b0;
  logic        tload = 1'b0, yload = 1'b0;
  logic [31:0] tval = '0, tmatch = '0;
  logic [15:0] yval = '0, ymatch = '0;
  logic [31:0] time_w;
  logic [15:0] year_w;
  logic        alarm;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bcd_cal_rtc dut_i (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick),
    .time_load_i(tload), .time_load_val_i(tval),
    .year_load_i(yload), .year_load_val_i(yval),
    .time_match_i(tmatch), .year_match_i(ymatch),
    .time_o(time_w), .year_o(year_w), .alarm_o(alarm)
  );

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %h expected %h", req, got, exp);
    end
  endtask

  task automatic load_both(input logic [31:0] t, input logic [15:0] y);
    @(negedge clk); tload = 1'b1; yload = 1'b1; tval = t; yval = y;
    @(negedge clk); tload = 1'b0; yload = 1'b0;
  endtask

  task automatic tick_once();
    @(negedge clk); tick = 1'b1;
    @(negedge clk); tick = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset values
    chk("R1 time", time_w, 32'h021E0000);
    chk("R1 mask", time_w & 32'h1FFE0000, 32'h021E0000);
    chk("R1 year", {16'h0, year_w}, 32'h00002000);
    chk("R1 alarm", {31'h0, alarm}, 32'h0);

    // R2-R7 vector walk
    for (int i = 0; i < NVEC; i++) begin
      load_both(VEC[i][95:64], VEC[i][63:48]);
      tick_once();
      chk($sformatf("R2-vec%0d time", i), time_w, VEC[i][47:16]);
      chk($sformatf("R7-vec%0d year", i), {16'h0, year_w}, {16'h0, VEC[i][15:0]});
    end

    // R2 hold without tick
    load_both(pk(7,4,5,10,20,30), 16'h2042);
    repeat (5) @(negedge clk);
    chk("R2 hold time", time_w, pk(7,4,5,10,20,30));
    chk("R2 hold year", {16'h0, year_w}, 32'h2042);

    // R9 alarm pulse on exact match
    tmatch = pk(1,1,7,0,0,1); ymatch = 16'h2000;
    load_both(pk(1,1,7,0,0,0), 16'h2000);
    chk("R9 idle before tick", {31'h0, alarm}, 32'h0);
    @(negedge clk); tick = 1'b1;
    @(negedge clk); tick = 1'b0;
    chk("R9 alarm high", {31'h0, alarm}, 32'h1);
    @(negedge clk);
    chk("R9 alarm one cycle", {31'h0, alarm}, 32'h0);

    // R10 year mismatch blocks alarm
    ymatch = 16'h2001;
    load_both(pk(1,1,7,0,0,0), 16'h2000);
    tick_once();
    chk("R10 year mismatch", {31'h0, alarm}, 32'h0);
    chk("R10 time advanced", time_w, pk(1,1,7,0,0,1));

    // R10 load of matching values gives no alarm
    ymatch = 16'h2000; tmatch = pk(1,1,7,0,0,5);
    @(negedge clk); tload = 1'b1; yload = 1'b1; tval = pk(1,1,7,0,0,5); yval = 16'h2000;
    @(negedge clk); tload = 1'b0; yload = 1'b0;
    chk("R10 load no alarm", {31'h0, alarm}, 32'h0);
    chk("R10 loaded", time_w, pk(1,1,7,0,0,5));

    // R8 load colliding with tick: load wins, no advance on either word
    @(negedge clk); tick = 1'b1; tload = 1'b1; tval = pk(8,8,3,8,8,8);
    @(negedge clk); tick = 1'b0; tload = 1'b0;
    chk("R8 load beats tick", time_w, pk(8,8,3,8,8,8));
    chk("R8 year blocked", {16'h0, year_w}, 32'h2000);

    // R8 year-only load, spare bits retained
    @(negedge clk); yload = 1'b1; yval = 16'h1234;
    @(negedge clk); yload = 1'b0;
    chk("R8 year load", {16'h0, year_w}, 32'h1234);
    chk("R8 time kept", time_w, pk(8,8,3,8,8,8));
    load_both(pk(3,3,3,3,3,3) | 32'hA000_0000, 16'h1234);
    tick_once();
    chk("R8 spare bits", time_w, pk(3,3,3,3,3,4) | 32'hA000_0000);

    // R3 second carry into minute, minute into hour
    load_both(pk(5,5,2,9,59,59), 16'h2030);
    tick_once();
    chk("R3 hour carry", time_w, pk(5,5,2,10,0,0));
    tick_once();
    chk("R3 plain step", time_w, pk(5,5,2,10,0,1));

    // R5 30-day month end and R6 century leap at 2400
    load_both(pk(11,30,4,23,59,59), 16'h2030);
    tick_once();
    chk("R5 november end", time_w, pk(12,1,5,0,0,0));
    load_both(pk(2,28,4,23,59,59), 16'h2400);
    tick_once();
    chk("R6 year 2400 leap", time_w, pk(2,29,5,0,0,0));

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule